// File: doc/BRIEF.md
# Strap-Configured Management Register Target

This block is the switch-side end of a clause-22 style management register bus. Each bus access carries a 5-bit bus address, a 5-bit register offset, a read or write strobe and 16-bit write data. The block decides from its strap inputs whether it answers, and if so where the access goes. Behind it sits a bank of internal devices. They are reached through one request/acknowledge register port whose latency varies from one access to the next.

Three decode schemes exist. With all address straps low and the dual-chip strap off, the block owns the whole bus and passes every access straight to the internal device of the same number. With the dual-chip strap on, only the top address strap counts: the block owns one half of the address space and forwards the low four address bits as the device number. With a non-zero strap and the dual-chip strap off, the block answers at a single even address only. There it exposes a command register and a data register, and these drive internal accesses one at a time under a busy flag that software polls.

Bus strobes are held until `bus_ack`. In the direct schemes `bus_ack` follows the internal acknowledge. For the command and data registers it is given in the same cycle.

Top module: `smi_target`

## Requirements
- R1: With `strap_id` = 0 and `strap_dual` = 0, every bus address is answered, and the access goes to internal device `bus_addr`, register `bus_reg`. `bus_ack` and the read data follow the internal acknowledge.
- R2: With `strap_dual` = 1, the block answers only when `bus_addr[4]` equals `strap_id[3]`, and it forwards the access to internal device `{1'b0, bus_addr[3:0]}`.
- R3: With `strap_id` != 0 and `strap_dual` = 0, the block answers only at bus address `{strap_id, 1'b0}`, and it never forwards a bus access directly to the internal port.
- R4: In the indirect scheme, offset 0 reads as {busy, stored command bits 14:0} and offset 1 reads as the data register. Other offsets read 0x0000 and ignore writes.
- R5: A command write with bit 15 = 1, bit 12 = 1 and bits [11:10] = 01 starts an internal write. The data register goes to device bits [9:5], register bits [4:0], and the request is held until it is acknowledged.
- R6: A command with bits [11:10] = 10 starts an internal read, and the acknowledged read data is loaded into the data register.
- R7: Busy reads 1 from the cycle after an accepted start until the cycle of the internal acknowledge, and reads 0 from the following cycle.
- R8: While busy is set, writes to the command and data registers are ignored.
- R9: A command with bit 15 = 1 but bit 12 = 0, or with bits [11:10] of 00 or 11, starts no internal access and leaves busy at 0.
- R10: An access that is not answered leaves `bus_hit` and `bus_ack` at 0 and `bus_rdata` at 0x0000. `bus_rdata` is 0x0000 whenever no read is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_id | input | 4 | Strapped bus address bits [4:1] |
| strap_dual | input | 1 | Selects the half-bus dual-chip decode |
| bus_addr | input | 5 | Bus address of the access |
| bus_reg | input | 5 | Register offset of the access |
| bus_rd | input | 1 | Read strobe, held until acknowledge |
| bus_wr | input | 1 | Write strobe, held until acknowledge |
| bus_wdata | input | 16 | Write data |
| bus_hit | output | 1 | The access is answered by this block |
| bus_ack | output | 1 | Access completes this cycle |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| int_req | output | 1 | Internal port request |
| int_we | output | 1 | Internal port write enable |
| int_dev | output | 5 | Internal device number |
| int_reg | output | 5 | Internal register number |
| int_wdata | output | 16 | Internal write data |
| int_ack | input | 1 | Internal port acknowledge |
| int_rdata | input | 16 | Internal port read data |

## Verification
The checker watches the decode on every cycle. It confirms that unmatched addresses are never driven in any scheme, that the full-bus scheme always forwards, that offsets above 1 read zero, that an indirect request holds until acknowledged without its target moving under a command write, and that malformed commands raise no request. The order of operations can only be shown by the bench's scenarios. These include a write through the data register followed by a read that returns the same value, a busy flag that is seen set and then cleared under a slow internal port, data left unchanged after an ignored write, and a value written through the half-bus scheme that reappears at the device the full-bus scheme addresses.

// File: rtl/smi_pkg.sv
package smi_pkg;
  typedef enum logic [1:0] {
    MODE_FULL   = 2'd0,
    MODE_HALF   = 2'd1,
    MODE_SHARED = 2'd2
  } smi_mode_e;

  localparam int CMD_BUSY_BIT = 15;
  localparam int CMD_C22_BIT  = 12;
  localparam int CMD_OP_HI    = 11;
  localparam int CMD_OP_LO    = 10;
  localparam int CMD_DEV_HI   = 9;
  localparam int CMD_DEV_LO   = 5;
  localparam int CMD_REG_HI   = 4;
  localparam int CMD_REG_LO   = 0;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/smi_addr_decode.sv
module smi_addr_decode
  import smi_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-2:0] strap_id,
  input  logic              strap_dual,
  input  logic [ADDR_W-1:0] bus_addr,
  output smi_mode_e         mode,
  output logic              addr_match,
  output logic [ADDR_W-1:0] direct_dev
);
  localparam int STRAP_W = ADDR_W - 1;

  always_comb begin
    if (strap_dual) begin
      mode       = MODE_HALF;
      addr_match = (bus_addr[ADDR_W-1] == strap_id[STRAP_W-1]);
      direct_dev = {1'b0, bus_addr[ADDR_W-2:0]};
    end else if (strap_id == '0) begin
      mode       = MODE_FULL;
      addr_match = 1'b1;
      direct_dev = bus_addr;
    end else begin
      mode       = MODE_SHARED;
      addr_match = (bus_addr == {strap_id, 1'b0});
      direct_dev = bus_addr;
    end
  end
endmodule

// File: rtl/smi_indirect_engine.sv
module smi_indirect_engine
  import smi_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DEV_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_hit,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_reg,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              port_req,
  output logic              port_we,
  output logic [DEV_W-1:0]  port_dev,
  output logic [REG_W-1:0]  port_reg,
  output logic [DATA_W-1:0] port_wdata,
  input  logic              port_ack,
  input  logic [DATA_W-1:0] port_rdata
);
  localparam int CMD_W = DATA_W - 1;

  logic              busy_q, busy_d;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q, data_d;
  logic              cmd_sel, data_sel;
  logic              cmd_wr_en, data_en, launch, finish;
  logic [1:0]        wr_op;

  assign cmd_sel  = acc_hit && (bus_reg == '0);
  assign data_sel = acc_hit && (bus_reg == REG_W'(1));
  assign wr_op    = bus_wdata[CMD_OP_HI:CMD_OP_LO];

  always_comb begin
    cmd_wr_en = cmd_sel && bus_wr && !busy_q;
    launch    = cmd_wr_en && bus_wdata[CMD_BUSY_BIT] && bus_wdata[CMD_C22_BIT]
                && ((wr_op == OP_WRITE) || (wr_op == OP_READ));
    finish    = busy_q && port_ack;
    busy_d    = busy_q;
    if (launch)      busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    data_en   = (data_sel && bus_wr && !busy_q) || (finish && !port_we);
    data_d    = finish ? port_rdata : bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (cmd_wr_en) cmd_q  <= bus_wdata[CMD_W-1:0];
      if (data_en)   data_q <= data_d;
    end
  end

  assign port_req   = busy_q;
  assign port_we    = (cmd_q[CMD_OP_HI:CMD_OP_LO] == OP_WRITE);
  assign port_dev   = DEV_W'(cmd_q[CMD_DEV_HI:CMD_DEV_LO]);
  assign port_reg   = REG_W'(cmd_q[CMD_REG_HI:CMD_REG_LO]);
  assign port_wdata = data_q;

  always_comb begin
    reg_rdata = '0;
    if (bus_rd && cmd_sel)       reg_rdata = {busy_q, cmd_q};
    else if (bus_rd && data_sel) reg_rdata = data_q;
  end
endmodule

// File: rtl/smi_port_mux.sv
module smi_port_mux #(
  parameter int REG_W  = 5,
  parameter int DEV_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              sel_indirect,
  input  logic              hit,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DEV_W-1:0]  dir_dev,
  input  logic [REG_W-1:0]  bus_reg,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              eng_req,
  input  logic              eng_we,
  input  logic [DEV_W-1:0]  eng_dev,
  input  logic [REG_W-1:0]  eng_reg,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic [DATA_W-1:0] eng_rdata,
  input  logic              int_ack,
  input  logic [DATA_W-1:0] int_rdata,
  output logic              int_req,
  output logic              int_we,
  output logic [DEV_W-1:0]  int_dev,
  output logic [REG_W-1:0]  int_reg,
  output logic [DATA_W-1:0] int_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata
);
  always_comb begin
    if (sel_indirect) begin
      int_req   = eng_req;
      int_we    = eng_we;
      int_dev   = eng_dev;
      int_reg   = eng_reg;
      int_wdata = eng_wdata;
      bus_ack   = hit;
      bus_rdata = eng_rdata;
    end else begin
      int_req   = hit;
      int_we    = bus_wr;
      int_dev   = dir_dev;
      int_reg   = bus_reg;
      int_wdata = bus_wdata;
      bus_ack   = hit && int_ack;
      bus_rdata = (hit && bus_rd && int_ack) ? int_rdata : '0;
    end
  end
endmodule

// File: rtl/smi_target.sv
module smi_target
  import smi_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-2:0] strap_id,
  input  logic              strap_dual,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_reg,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_hit,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              int_req,
  output logic              int_we,
  output logic [ADDR_W-1:0] int_dev,
  output logic [REG_W-1:0]  int_reg,
  output logic [DATA_W-1:0] int_wdata,
  input  logic              int_ack,
  input  logic [DATA_W-1:0] int_rdata
);
  localparam int DEV_W = ADDR_W;

  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  smi_mode_e         mode;
  logic              addr_match, hit, sel_indirect;
  logic [DEV_W-1:0]  dir_dev;
  logic [DATA_W-1:0] eng_rdata, eng_wdata;
  logic              eng_req, eng_we;
  logic [DEV_W-1:0]  eng_dev;
  logic [REG_W-1:0]  eng_reg;

  smi_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .strap_id   (strap_id),
    .strap_dual (strap_dual),
    .bus_addr   (bus_addr),
    .mode       (mode),
    .addr_match (addr_match),
    .direct_dev (dir_dev)
  );

  assign hit          = addr_match && (bus_rd || bus_wr);
  assign sel_indirect = (mode == MODE_SHARED);
  assign bus_hit      = hit;

  smi_indirect_engine #(.REG_W(REG_W), .DEV_W(DEV_W), .DATA_W(DATA_W)) u_eng (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .acc_hit    (hit && sel_indirect),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_reg    (bus_reg),
    .bus_wdata  (bus_wdata),
    .reg_rdata  (eng_rdata),
    .port_req   (eng_req),
    .port_we    (eng_we),
    .port_dev   (eng_dev),
    .port_reg   (eng_reg),
    .port_wdata (eng_wdata),
    .port_ack   (int_ack && sel_indirect),
    .port_rdata (int_rdata)
  );

  smi_port_mux #(.REG_W(REG_W), .DEV_W(DEV_W), .DATA_W(DATA_W)) u_mux (
    .sel_indirect (sel_indirect),
    .hit          (hit),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .dir_dev      (dir_dev),
    .bus_reg      (bus_reg),
    .bus_wdata    (bus_wdata),
    .eng_req      (eng_req),
    .eng_we       (eng_we),
    .eng_dev      (eng_dev),
    .eng_reg      (eng_reg),
    .eng_wdata    (eng_wdata),
    .eng_rdata    (eng_rdata),
    .int_ack      (int_ack),
    .int_rdata    (int_rdata),
    .int_req      (int_req),
    .int_we       (int_we),
    .int_dev      (int_dev),
    .int_reg      (int_reg),
    .int_wdata    (int_wdata),
    .bus_ack      (bus_ack),
    .bus_rdata    (bus_rdata)
  );
endmodule

// File: rtl/smi_target_chk.sv
module smi_target_chk #(
  parameter int ADDR_W = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-2:0] strap_id,
  input logic              strap_dual,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_reg,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_hit,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              int_req,
  input logic [ADDR_W-1:0] int_dev,
  input logic [REG_W-1:0]  int_reg,
  input logic              int_ack
);
  logic full_m, half_m, shared_m, acc;
  assign full_m   = (strap_id == '0) && !strap_dual;
  assign half_m   = strap_dual;
  assign shared_m = (strap_id != '0) && !strap_dual;
  assign acc      = bus_rd || bus_wr;

  // R1
  full_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_m && acc) |-> (bus_hit && int_req));

  // R2
  half_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_m && acc && (bus_addr[ADDR_W-1] != strap_id[ADDR_W-2])) |-> (!bus_hit && !int_req));

  // R3
  shared_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_m && (bus_addr != {strap_id, 1'b0})) |-> (!bus_hit && !bus_ack));

  // R4
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_m && bus_hit && bus_rd && (bus_reg > REG_W'(1))) |-> (bus_ack && bus_rdata == '0));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_m && int_req && !int_ack) |=> int_req);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_m && int_req && !int_ack && bus_hit && bus_wr && bus_reg == '0)
      |=> (int_req && $stable(int_dev) && $stable(int_reg)));

  // R9
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_m && !int_req && bus_hit && bus_wr && bus_reg == '0 && bus_wdata[15] && !bus_wdata[12])
      |=> !int_req);

  // R10
  no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> (!bus_ack && bus_rdata == '0));
endmodule

bind smi_target smi_target_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strap_id   (strap_id),
  .strap_dual (strap_dual),
  .bus_addr   (bus_addr),
  .bus_reg    (bus_reg),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_hit    (bus_hit),
  .bus_ack    (bus_ack),
  .bus_rdata  (bus_rdata),
  .int_req    (int_req),
  .int_dev    (int_dev),
  .int_reg    (int_reg),
  .int_ack    (int_ack)
);

// File: tb/smi_target_test.sv
module smi_target_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  strap_id = '0;
  logic        strap_dual = 1'b0;
  logic [4:0]  bus_addr = '0, bus_reg = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_hit, bus_ack, int_req, int_we;
  logic [15:0] bus_rdata, int_wdata;
  logic [4:0]  int_dev, int_reg;
  logic        dev_ack;
  logic [15:0] dev_rdata;

  always #10 clk = ~clk;

  smi_target uut (
    .clk(clk), .rst_n(rst_n), .strap_id(strap_id), .strap_dual(strap_dual),
    .bus_addr(bus_addr), .bus_reg(bus_reg), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_hit(bus_hit), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .int_req(int_req), .int_we(int_we), .int_dev(int_dev), .int_reg(int_reg),
    .int_wdata(int_wdata), .int_ack(dev_ack), .int_rdata(dev_rdata)
  );

  int vectors = 0, errors = 0, cycles = 0;
  int lat_sel = 0, dev_wait = 0;
  logic [15:0] dev_mem [0:1023];

  // internal device bank with programmable latency
  assign dev_ack   = int_req && (dev_wait >= lat_sel);
  assign dev_rdata = dev_mem[{int_dev, int_reg}];

  always @(posedge clk) begin
    if (int_req && !dev_ack) dev_wait <= dev_wait + 1;
    else                     dev_wait <= 0;
    if (int_req && dev_ack && int_we) dev_mem[{int_dev, int_reg}] <= int_wdata;
  end

  // behavioural reference
  logic        m_busy;
  logic [14:0] m_cmd;
  logic [15:0] m_data;
  logic        e_hit, e_ack, e_req, e_we, shared_m, match;
  logic [15:0] e_rdata, e_wdata;
  logic [4:0]  e_dev, e_reg;

  always @* begin
    shared_m = (strap_id != 0) && !strap_dual;
    if (strap_dual)         match = (bus_addr[4] == strap_id[3]);
    else if (strap_id == 0) match = 1'b1;
    else                    match = (bus_addr == {strap_id, 1'b0});
    e_hit = match && (bus_rd || bus_wr);
    e_rdata = 16'h0;
    if (shared_m) begin
      e_req = m_busy; e_dev = m_cmd[9:5]; e_reg = m_cmd[4:0];
      e_we = (m_cmd[11:10] == 2'b01); e_wdata = m_data; e_ack = e_hit;
      if (e_hit && bus_rd)
        e_rdata = (bus_reg == 0) ? {m_busy, m_cmd} : (bus_reg == 1) ? m_data : 16'h0;
    end else begin
      e_req = e_hit; e_dev = strap_dual ? {1'b0, bus_addr[3:0]} : bus_addr;
      e_reg = bus_reg; e_we = bus_wr; e_wdata = bus_wdata; e_ack = e_hit && dev_ack;
      if (e_ack && bus_rd) e_rdata = dev_mem[{e_dev, e_reg}];
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_cmd <= '0; m_data <= '0;
    end else if (shared_m) begin
      if (e_hit && bus_wr && bus_reg == 0 && !m_busy) begin
        m_cmd  <= bus_wdata[14:0];
        m_busy <= bus_wdata[15] && bus_wdata[12] &&
                  (bus_wdata[11:10] == 2'b01 || bus_wdata[11:10] == 2'b10);
      end
      if (e_hit && bus_wr && bus_reg == 1 && !m_busy) m_data <= bus_wdata;
      if (m_busy && dev_ack) begin
        m_busy <= 1'b0;
        if (m_cmd[11:10] == 2'b10) m_data <= dev_mem[{m_cmd[9:5], m_cmd[4:0]}];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string hit_req();
    if (strap_dual) return "R2";
    if (strap_id == 0) return "R1";
    return "R3";
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    chk(hit_req(), "bus_hit", {15'h0, bus_hit}, {15'h0, e_hit});
    chk("R10", "bus_ack", {15'h0, bus_ack}, {15'h0, e_ack});
    chk("R4", "bus_rdata", bus_rdata, e_rdata);
    chk("R7", "int_req", {15'h0, int_req}, {15'h0, e_req});
    if (e_req) begin
      chk("R5", "int_dev", {11'h0, int_dev}, {11'h0, e_dev});
      chk("R5", "int_reg", {11'h0, int_reg}, {11'h0, e_reg});
      chk("R6", "int_we", {15'h0, int_we}, {15'h0, e_we});
      if (e_we) chk("R5", "int_wdata", int_wdata, e_wdata);
    end
  end

  task automatic xfer(input logic wr, input logic [4:0] a, input logic [4:0] r,
                      input logic [15:0] d, output logic [15:0] q, output logic acked);
    @(posedge clk); #1;
    bus_addr = a; bus_reg = r; bus_wdata = d; bus_wr = wr; bus_rd = !wr;
    acked = 1'b0; q = 16'h0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_ack) begin acked = 1'b1; q = bus_rdata; break; end
    end
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic restart(input logic [3:0] s, input logic dual);
    @(posedge clk); #1;
    rst_n = 1'b0; strap_id = s; strap_dual = dual;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic poll_idle(input logic [4:0] a, output logic saw_busy);
    logic [15:0] q; logic k;
    saw_busy = 1'b0;
    for (int i = 0; i < 30; i++) begin
      xfer(1'b0, a, 5'd0, 16'h0, q, k);
      if (q[15]) saw_busy = 1'b1;
      else break;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++; vectors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] q; logic k, sb;
    for (int i = 0; i < 1024; i++) dev_mem[i] = 16'(i * 37) ^ 16'h5a00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset bus_hit", {15'h0, bus_hit}, 16'h0);
    chk("R7", "reset int_req", {15'h0, int_req}, 16'h0);
    #5 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 full-bus direct access
    lat_sel = 2;
    xfer(1'b1, 5'd3, 5'd7, 16'hA55A, q, k); chk("R1", "write ack", {15'h0, k}, 16'h1);
    xfer(1'b0, 5'd3, 5'd7, 16'h0, q, k);    chk("R1", "read dev3 reg7", q, 16'hA55A);
    xfer(1'b0, 5'd31, 5'd1, 16'h0, q, k);   chk("R1", "read dev31 reg1", q, 16'(((31*32)+1)*37) ^ 16'h5a00);

    // R2 half-bus decode, upper half
    restart(4'b1000, 1'b1);
    xfer(1'b1, 5'd21, 5'd2, 16'hBEEF, q, k); chk("R2", "upper write ack", {15'h0, k}, 16'h1);
    xfer(1'b0, 5'd3, 5'd2, 16'h0, q, k);     chk("R2", "lower half ignored", {15'h0, k}, 16'h0);
    restart(4'b0000, 1'b0);
    xfer(1'b0, 5'd5, 5'd2, 16'h0, q, k);     chk("R2", "offset maps to dev5", q, 16'hBEEF);
    restart(4'b0110, 1'b1);
    xfer(1'b0, 5'd3, 5'd7, 16'h0, q, k);     chk("R2", "lower half dev3", q, 16'hA55A);
    xfer(1'b0, 5'd19, 5'd7, 16'h0, q, k);    chk("R2", "upper miss", {15'h0, k}, 16'h0);

    // R3 shared bus at address 6
    restart(4'b0011, 1'b0);
    lat_sel = 3;
    xfer(1'b0, 5'd7, 5'd1, 16'h0, q, k);     chk("R3", "odd neighbour miss", {15'h0, k}, 16'h0);
    xfer(1'b0, 5'd0, 5'd0, 16'h0, q, k);     chk("R10", "address 0 miss data", q, 16'h0);
    xfer(1'b1, 5'd6, 5'd1, 16'h1234, q, k);
    xfer(1'b1, 5'd6, 5'd0, 16'h9000 | 16'h0400 | (16'd9 << 5) | 16'd4, q, k);
    poll_idle(5'd6, sb);                     chk("R7", "busy seen then cleared", {15'h0, sb}, 16'h1);
    chk("R5", "device written", dev_mem[{5'd9, 5'd4}], 16'h1234);
    xfer(1'b1, 5'd6, 5'd1, 16'h0000, q, k);
    xfer(1'b1, 5'd6, 5'd0, 16'h9000 | 16'h0800 | (16'd9 << 5) | 16'd4, q, k);
    poll_idle(5'd6, sb);
    xfer(1'b0, 5'd6, 5'd1, 16'h0, q, k);     chk("R6", "read result in data reg", q, 16'h1234);

    // R8 writes while busy are dropped
    lat_sel = 8;
    xfer(1'b1, 5'd6, 5'd0, 16'h9000 | 16'h0800 | (16'd3 << 5) | 16'd7, q, k);
    xfer(1'b1, 5'd6, 5'd0, 16'h9000 | 16'h0400 | (16'd1 << 5) | 16'd1, q, k);
    xfer(1'b1, 5'd6, 5'd1, 16'hDEAD, q, k);
    xfer(1'b0, 5'd6, 5'd0, 16'h0, q, k);     chk("R8", "command unchanged", q, 16'h9000 | 16'h0800 | (16'd3 << 5) | 16'd7);
    poll_idle(5'd6, sb);
    xfer(1'b0, 5'd6, 5'd1, 16'h0, q, k);     chk("R8", "data from device", q, 16'hA55A);

    // R9 malformed commands
    lat_sel = 0;
    xfer(1'b1, 5'd6, 5'd0, 16'h8000 | 16'h0800 | 16'd2, q, k);
    xfer(1'b0, 5'd6, 5'd0, 16'h0, q, k);     chk("R9", "no clause bit", q, 16'h0800 | 16'd2);
    xfer(1'b1, 5'd6, 5'd0, 16'h9000 | 16'h0C00 | 16'd2, q, k);
    xfer(1'b0, 5'd6, 5'd0, 16'h0, q, k);     chk("R9", "opcode 11", q, 16'h1000 | 16'h0C00 | 16'd2);

    // R4 spare offsets
    xfer(1'b1, 5'd6, 5'd5, 16'h7777, q, k);
    xfer(1'b0, 5'd6, 5'd5, 16'h0, q, k);     chk("R4", "offset 5 reads zero", q, 16'h0);
    xfer(1'b0, 5'd6, 5'd1, 16'h0, q, k);     chk("R4", "data reg untouched", q, 16'hA55A);

    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule